// File: doc/BRIEF.md
# Strided Row Address Generator

This block walks a rectangular region of memory one row at a time. A single start pulse captures a base address, a row length, a row count and a row pitch. The block then issues one request per row. Each request carries the row's first byte address and its byte length. The pitch is set apart from the row length, so any gap between the end of one row and the start of the next is skipped. This gives a plain linear copy, a sub-window of a larger frame, or a column of tiles from the same control.

Both the row length and the row count are supplied as the real value minus one. The low address bits below the bus alignment are dropped from the base and the pitch. The same low bits of the row length are forced to ones, so every row is a whole number of bus words. The two-dimensional variant is chosen by a parameter. When it is off, the row count is treated as zero and exactly one row is produced.

The controller has three states:
- `ST_IDLE`: waits for `start`. Transition IDLE→ISSUE on `start`.
- `ST_ISSUE`: presents one row request at a time. It stays in ISSUE after a handshake on any row but the last. Transition ISSUE→FINISH on the handshake of the last row.
- `ST_FINISH`: raises `done` for one cycle. Transition FINISH→IDLE is unconditional.

Top module: `strided_agen`

## Requirements
- R1: After reset, `busy`, `done` and `req_valid` are low and `cur_addr` is zero.
- R2: A `start` pulse seen in idle captures all configuration inputs. The first request is presented in the next cycle, together with `busy`.
- R3: Row k (counting from 0) requests address `aligned_base + k * aligned_pitch`, taken modulo 2^ADDR_W.
- R4: Every row request has byte length `(row_len_m1 | (2^ALIGN_LG - 1)) + 1`. An all-ones `row_len_m1` gives the largest length, 2^LEN_W.
- R5: With two-dimensional mode enabled, exactly `row_cnt_m1 + 1` rows are requested. With it disabled, exactly one row is requested whatever `row_cnt_m1` holds.
- R6: While `req_valid` is high and `req_ready` is low, the request address and length stay unchanged in the next cycle.
- R7: `done` is high for exactly one cycle, the cycle after the final row's handshake. In the cycle after that, the block is idle with `busy` low.
- R8: `start` and any configuration change while `busy` is high have no effect on the running sequence.
- R9: `cur_addr` equals the address of the row being requested. After completion it keeps the last row's address.
- R10: Address bits below ALIGN_LG in `base_addr` and in `row_pitch` are ignored, so requested addresses and lengths are multiples of 2^ALIGN_LG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a region walk (honoured only when idle) |
| base_addr | input | ADDR_W | Byte address of the first row |
| row_len_m1 | input | LEN_W | Row length in bytes minus one |
| row_cnt_m1 | input | CNT_W | Number of rows minus one |
| row_pitch | input | ADDR_W | Byte distance between starts of consecutive rows |
| req_ready | input | 1 | Consumer accepts the current row request |
| req_valid | output | 1 | A row request is presented |
| req_addr | output | ADDR_W | Start address of the requested row |
| req_len | output | LEN_W+1 | Byte length of the requested row |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse after the last row is accepted |
| cur_addr | output | ADDR_W | Current row address for status readback |

## Verification
The bench builds two copies of the block. Both use a 16-bit address, a 6-bit row length field, a 3-bit row count and 4-byte alignment. One copy has two-dimensional mode enabled and the other has it disabled. The small fields make it possible to sweep every row count from one to eight, with row lengths that include both the minimum and the all-ones maximum. Bases and pitches are chosen so that the address wraps around the 16-bit space and so that the alignment bits are set, which exercises the masking of those bits. Each walk runs under both an always-ready consumer and a stalling consumer. About half of the walks also pulse `start` and scramble the configuration while busy.

// File: rtl/agen_pkg.sv
package agen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } agen_state_e;
endpackage

// File: rtl/agen_cfg_norm.sv
module agen_cfg_norm #(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 6,
    parameter int CNT_W    = 3,
    parameter int ALIGN_LG = 2,
    parameter bit EN_2D    = 1'b1
) (
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] pitch_in,
    input  logic [LEN_W-1:0]  len_m1_in,
    input  logic [CNT_W-1:0]  cnt_m1_in,
    output logic [ADDR_W-1:0] base_al,
    output logic [ADDR_W-1:0] pitch_al,
    output logic [LEN_W:0]    row_bytes,
    output logic [CNT_W-1:0]  rows_m1
);
    localparam logic [ADDR_W-1:0] ADDR_LOW = ADDR_W'((1 << ALIGN_LG) - 1);
    localparam logic [LEN_W-1:0]  LEN_LOW  = LEN_W'((1 << ALIGN_LG) - 1);

    assign base_al   = base_in  & ~ADDR_LOW;
    assign pitch_al  = pitch_in & ~ADDR_LOW;
    assign row_bytes = {1'b0, len_m1_in | LEN_LOW} + {{LEN_W{1'b0}}, 1'b1};

    generate
        if (EN_2D) begin : g_two_dim
            assign rows_m1 = cnt_m1_in;
        end else begin : g_one_dim
            assign rows_m1 = cnt_m1_in & {CNT_W{1'b0}};
        end
    endgenerate
endmodule

// File: rtl/agen_row_ctr.sv
module agen_row_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_last
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign is_last = (left_q == '0);
endmodule

// File: rtl/agen_addr_acc.sv
module agen_addr_acc #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic [ADDR_W-1:0] pitch,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + pitch;
        end
    end
endmodule

// File: rtl/strided_agen.sv
module strided_agen
    import agen_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 6,
    parameter int CNT_W    = 3,
    parameter int ALIGN_LG = 2,
    parameter bit EN_2D    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  row_len_m1,
    input  logic [CNT_W-1:0]  row_cnt_m1,
    input  logic [ADDR_W-1:0] row_pitch,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W:0]    req_len,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] cur_addr
);
    agen_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_al, pitch_al, pitch_q, addr_q;
    logic [LEN_W:0]    row_bytes, len_q;
    logic [CNT_W-1:0]  rows_m1;
    logic              launch, accept, last_row;

    agen_cfg_norm #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
        .ALIGN_LG(ALIGN_LG), .EN_2D(EN_2D)
    ) u_norm (
        .base_in  (base_addr),
        .pitch_in (row_pitch),
        .len_m1_in(row_len_m1),
        .cnt_m1_in(row_cnt_m1),
        .base_al  (base_al),
        .pitch_al (pitch_al),
        .row_bytes(row_bytes),
        .rows_m1  (rows_m1)
    );

    assign launch = (state_q == ST_IDLE) && start;
    assign accept = (state_q == ST_ISSUE) && req_ready;

    agen_row_ctr #(.CNT_W(CNT_W)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .load_val(rows_m1),
        .dec     (accept && !last_row),
        .is_last (last_row)
    );

    agen_addr_acc #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .load_val(base_al),
        .step    (accept && !last_row),
        .pitch   (pitch_q),
        .addr    (addr_q)
    );

    // captured per-walk length and pitch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            pitch_q <= '0;
        end else if (launch) begin
            len_q   <= row_bytes;
            pitch_q <= pitch_al;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ISSUE;
            ST_ISSUE:  if (req_ready && last_row) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_valid = (state_q == ST_ISSUE);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        req_addr  = addr_q;
        req_len   = len_q;
        cur_addr  = addr_q;
    end
endmodule

// File: rtl/strided_agen_chk.sv
module strided_agen_chk #(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 6,
    parameter int ALIGN_LG = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W:0]    req_len,
    input logic              busy,
    input logic              done
);
    localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'((1 << ALIGN_LG) - 1);
    localparam logic [LEN_W:0]    L_LOW = (LEN_W+1)'((1 << ALIGN_LG) - 1);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

    // R7
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(req_valid && req_ready));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R2
    valid_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    // R10
    aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (((req_addr & A_LOW) == '0) && ((req_len & L_LOW) == '0) && (req_len != '0)));
endmodule

bind strided_agen strided_agen_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN_LG(ALIGN_LG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .req_len  (req_len),
    .busy     (busy),
    .done     (done)
);

// File: tb/strided_agen_bench.sv
`timescale 1ns/1ps
module strided_agen_bench;
    localparam int AW = 16;
    localparam int LW = 6;
    localparam int CW = 3;
    localparam int AL = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, start_a, start_b, ready, use_b;
    logic [AW-1:0] base, pitch;
    logic [LW-1:0] rlen;
    logic [CW-1:0] rcnt;

    logic          a_valid, a_busy, a_done, b_valid, b_busy, b_done;
    logic [AW-1:0] a_addr, a_cur, b_addr, b_cur;
    logic [LW:0]   a_len, b_len;

    strided_agen #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW), .ALIGN_LG(AL), .EN_2D(1'b1)) u_strided_agen (
        .clk(clk), .rst_n(rst_n), .start(start_a), .base_addr(base), .row_len_m1(rlen),
        .row_cnt_m1(rcnt), .row_pitch(pitch), .req_ready(ready), .req_valid(a_valid),
        .req_addr(a_addr), .req_len(a_len), .busy(a_busy), .done(a_done), .cur_addr(a_cur));

    strided_agen #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW), .ALIGN_LG(AL), .EN_2D(1'b0)) u_strided_agen_1d (
        .clk(clk), .rst_n(rst_n), .start(start_b), .base_addr(base), .row_len_m1(rlen),
        .row_cnt_m1(rcnt), .row_pitch(pitch), .req_ready(ready), .req_valid(b_valid),
        .req_addr(b_addr), .req_len(b_len), .busy(b_busy), .done(b_done), .cur_addr(b_cur));

    wire          m_valid = use_b ? b_valid : a_valid;
    wire          m_busy  = use_b ? b_busy  : a_busy;
    wire          m_done  = use_b ? b_done  : a_done;
    wire [AW-1:0] m_addr  = use_b ? b_addr  : a_addr;
    wire [AW-1:0] m_cur   = use_b ? b_cur   : a_cur;
    wire [LW:0]   m_len   = use_b ? b_len   : a_len;

    int nvec = 0;
    int nbad = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic walk(input bit sel, input logic [AW-1:0] b, input logic [LW-1:0] l,
                        input logic [CW-1:0] c, input logic [AW-1:0] s,
                        input bit stall, input bit poke);
        int            nrows = sel ? 1 : int'(c) + 1;
        int            blen  = int'(l | LW'(3)) + 1;
        logic [AW-1:0] ab    = b & ~AW'(3);
        logic [AW-1:0] as    = s & ~AW'(3);
        logic [AW-1:0] exp_a = ab;
        int            k     = 0;
        int            cyc   = 0;
        use_b = sel;
        base = b; rlen = l; rcnt = c; pitch = s;
        if (sel) start_b = 1'b1; else start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0; start_b = 1'b0;
        chk("R2 busy after start", m_busy, 1);
        while (k < nrows && cyc < 100) begin
            exp_a = ab + AW'(k) * as;
            if (poke && cyc == 1) begin
                // R8: restart attempt with scrambled configuration
                if (sel) start_b = 1'b1; else start_a = 1'b1;
                base = b ^ AW'(16'h0140); rlen = ~l; rcnt = ~c; pitch = s + AW'(16'h0020);
            end else begin
                start_a = 1'b0; start_b = 1'b0;
            end
            ready = stall ? (cyc % 3 != 2) : 1'b1;
            chk("R2/R5 request valid", m_valid, 1);
            chk("R3/R6/R8/R10 row address", m_addr, exp_a);
            chk("R4/R8 row length", m_len, blen);
            chk("R9 current address", m_cur, exp_a);
            if (ready) k++;
            cyc++;
            @(negedge clk);
        end
        start_a = 1'b0; start_b = 1'b0; ready = 1'b0;
        chk("R5/R7 done after last row", m_done, 1);
        chk("R5 no extra row", m_valid, 0);
        @(negedge clk);
        chk("R7 done single cycle", m_done, 0);
        chk("R7 idle after done", m_busy, 0);
        chk("R9 last address kept", m_cur, exp_a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [AW-1:0] bases [2];
        logic [AW-1:0] pitches [3];
        logic [LW-1:0] lens [4];
        bases   = '{16'h0000, 16'hFFC3};
        pitches = '{16'h0004, 16'h0103, 16'h4000};
        lens    = '{6'd0, 6'd5, 6'd62, 6'd63};
        rst_n = 1'b0; start_a = 1'b0; start_b = 1'b0; ready = 1'b0; use_b = 1'b0;
        base = '0; rlen = '0; rcnt = '0; pitch = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", a_busy | b_busy, 0);
        chk("R1 reset done", a_done | b_done, 0);
        chk("R1 reset valid", a_valid | b_valid, 0);
        chk("R1 reset address", a_cur | b_cur, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int bi = 0; bi < 2; bi++)
            for (int li = 0; li < 4; li++)
                for (int c = 0; c < 8; c++)
                    for (int si = 0; si < 3; si++)
                        for (int st = 0; st < 2; st++)
                            walk(1'b0, bases[bi], lens[li], CW'(c), pitches[si], st[0], c[0]);
        // R5: one-dimensional copy ignores the row count
        for (int c = 0; c < 8; c++)
            for (int li = 0; li < 4; li++)
                walk(1'b1, 16'h1237, lens[li], CW'(c), 16'h0100, c[1], c[0]);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule